// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block collects fourteen peripheral interrupt requests, records each as a pending status bit, and hands the processor one 16-bit vector address for the most urgent thing awaiting service. Each source has an enable bit, a status bit and a clear bit at the same position in three registers. The sources are folded onto eight interrupt lines. The address of each line is fixed in the top words of the first 64K-word segment. A separate select register can move one whole line onto the fast interrupt vector instead.

Two event inputs, a soft reset request and a break request, hold pending flags of their own and outrank every peripheral line. The processor sees `irq_req` together with `irq_vec` and pulses `irq_ack` when it takes the vector. An acknowledge retires a pending break or reset. Peripheral status bits are only retired by software through the clear register. Each peripheral's own internal enable is outside the block and simply shapes the level on its `src_req` input.

Top module: `prio_vec_ctrl`

## Requirements
- R1: After reset the enable and status registers read 0 and the FIQ select register reads 8 (no line routed). `irq_req` is 0, `irq_vec` is 0x0000 and every `irq_line` bit is 0.
- R2: A 0-to-1 change on a `src_req` bit sets that status bit at the next clock edge. A request that stays high does not set it again after it has been cleared. A new rise sets it once more.
- R3: Writing register address 2 (clear) clears each status bit written as 1. If a source rises in the same cycle as its clear write, the status bit ends up set.
- R4: Address 0 (enable) loads the written bits. Address 1 (status) sets each bit written as 1. Address 3 (FIQ select) loads the low 4 bits. Through `rd_addr`, `rd_data` returns enable at 0, status at 1, zero at 2, and FIQ select at 3.
- R5: A line is active when at least one source mapped to it has both its status and its enable bit set. The mapping is: bit 3 to line 0, bit 2 to line 1, bits 12 and 11 to line 2, and bits 13, 10 and 9 to line 3. No source is on line 4. Bits 8 and 7 go to line 5, bit 6 to line 6, and bits 5, 4, 1 and 0 to line 7.
- R6: With only peripheral lines active, `irq_vec` is 0xFFF8 plus the index of the lowest-numbered active line. Line 0 has the highest priority.
- R7: When FIQ select holds a value n below 8, line n drives `fiq_line` instead of `irq_line[n]`. When that line is active, `irq_vec` is 0xFFF6, and this outranks every peripheral line.
- R8: A `brk_evt` pulse makes a break pending, giving vector 0xFFF5 above FIQ and the peripheral lines. An `rst_evt` pulse makes a reset pending, giving vector 0xFFF7 above everything else.
- R9: `irq_ack` while the vector is 0xFFF7 retires the pending reset. `irq_ack` while the vector is 0xFFF5 retires the pending break. An event arriving in the same cycle as the acknowledge stays pending. `irq_ack` while a FIQ or line vector is shown changes no status bit.
- R10: `irq_req` is 1 exactly when some vector is due. When nothing is due, `irq_vec` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 14 | Peripheral request levels, rising edge recorded |
| brk_evt | input | 1 | Break request pulse |
| rst_evt | input | 1 | Soft reset request pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register: 0 enable, 1 status set, 2 clear, 3 FIQ select |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 16 | Read data, combinational |
| irq_line | output | 8 | Active interrupt lines after FIQ routing |
| fiq_line | output | 1 | Line routed to the fast interrupt is active |
| irq_req | output | 1 | A vector is due |
| irq_vec | output | 16 | Vector address of the highest-priority item due |
| irq_ack | input | 1 | Processor takes the shown vector |

## Verification
Two pairs of actions can land on the same clock edge. A source can rise while software clears the same status bit, and a new break can arrive while the processor acknowledges an earlier break. The bench forces each pair by driving the edge and the write, or the event and the acknowledge, at the same falling edge. After the next rising edge it reads the status register, or the vector, to confirm that the new event was kept. A table of enable, status and FIQ-select patterns covers line mapping and priority among lines, FIQ and events.

// File: rtl/prio_vec_pkg.sv
package prio_vec_pkg;

  localparam int NUM_SRC  = 14;
  localparam int NUM_LINE = 8;
  localparam int DATA_W   = 16;

  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_STATUS = 2'd1,
    RA_CLEAR  = 2'd2,
    RA_FIQSEL = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    VK_IDLE,
    VK_RESET,
    VK_BREAK,
    VK_FIQ,
    VK_IRQ
  } vec_kind_e;

  // Source bit to interrupt line routing.
  function automatic int src_line(input int s);
    case (s)
      0, 1, 4, 5: src_line = 7;
      2:          src_line = 1;
      3:          src_line = 0;
      6:          src_line = 6;
      7, 8:       src_line = 5;
      9, 10, 13:  src_line = 3;
      11, 12:     src_line = 2;
      default:    src_line = s % NUM_LINE;
    endcase
  endfunction

  // Vector address: lines occupy the top n_line words, then reset, FIQ, break below.
  function automatic logic [DATA_W-1:0] vec_addr(input vec_kind_e k, input int line,
                                                  input int n_line);
    logic [DATA_W-1:0] base;
    base = '1 - DATA_W'(n_line) + DATA_W'(1);
    case (k)
      VK_RESET: vec_addr = base - DATA_W'(1);
      VK_FIQ:   vec_addr = base - DATA_W'(2);
      VK_BREAK: vec_addr = base - DATA_W'(3);
      VK_IRQ:   vec_addr = base + DATA_W'(line);
      default:  vec_addr = '0;
    endcase
  endfunction

endpackage

// File: rtl/prio_vec_srcreg.sv
module prio_vec_srcreg
  import prio_vec_pkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int N_LINE = NUM_LINE,
  parameter int DW     = DATA_W,
  parameter int FW     = $clog2(NUM_LINE) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [N_SRC-1:0]  en_q,
  output logic [N_SRC-1:0]  st_q,
  output logic [FW-1:0]     fsel_q,
  output logic [N_SRC-1:0]  edge_o
);

  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] clr_m;
  logic [N_SRC-1:0] set_m;
  logic             wr_en_reg;
  logic             wr_fsel;

  assign edge_o    = src_req & ~prev_q;
  assign clr_m     = (wr_en && wr_addr == RA_CLEAR)  ? wr_data[N_SRC-1:0] : '0;
  assign set_m     = (wr_en && wr_addr == RA_STATUS) ? wr_data[N_SRC-1:0] : '0;
  assign wr_en_reg = wr_en && wr_addr == RA_ENABLE;
  assign wr_fsel   = wr_en && wr_addr == RA_FIQSEL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      st_q   <= '0;
      en_q   <= '0;
      fsel_q <= FW'(N_LINE);
    end else begin
      prev_q <= src_req;
      st_q   <= (st_q & ~clr_m) | edge_o | set_m;
      if (wr_en_reg) en_q   <= wr_data[N_SRC-1:0];
      if (wr_fsel)   fsel_q <= wr_data[FW-1:0];
    end
  end

endmodule

// File: rtl/prio_vec_group.sv
module prio_vec_group
  import prio_vec_pkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int N_LINE = NUM_LINE,
  parameter int FW     = $clog2(NUM_LINE) + 1,
  parameter int LW     = $clog2(NUM_LINE)
) (
  input  logic [N_SRC-1:0]  st,
  input  logic [N_SRC-1:0]  en,
  input  logic [FW-1:0]     fsel,
  output logic [N_LINE-1:0] line_o,
  output logic              fiq_o
);

  logic [N_SRC-1:0]  act;
  logic [N_LINE-1:0] raw;
  logic [N_LINE-1:0] steal;
  logic              fsel_hit;

  assign act      = st & en;
  assign fsel_hit = int'(fsel) < N_LINE;

  always_comb begin
    raw = '0;
    for (int s = 0; s < N_SRC; s++) begin
      raw[LW'(src_line(s))] = raw[LW'(src_line(s))] | act[s];
    end
  end

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    assign steal[l]  = fsel_hit && (fsel[LW-1:0] == LW'(l));
    assign line_o[l] = raw[l] & ~steal[l];
  end

  assign fiq_o = |(raw & steal);

endmodule

// File: rtl/prio_vec_sel.sv
module prio_vec_sel
  import prio_vec_pkg::*;
#(
  parameter int N_LINE = NUM_LINE,
  parameter int DW     = DATA_W,
  parameter int LW     = $clog2(NUM_LINE)
) (
  input  logic              rst_pend,
  input  logic              brk_pend,
  input  logic              fiq,
  input  logic [N_LINE-1:0] lines,
  output vec_kind_e         kind,
  output logic [DW-1:0]     vec,
  output logic              req
);

  logic [LW-1:0] idx;

  always_comb begin
    kind = VK_IDLE;
    idx  = '0;
    for (int l = N_LINE - 1; l >= 0; l--) begin
      if (lines[l]) begin
        kind = VK_IRQ;
        idx  = LW'(l);
      end
    end
    if (fiq)      kind = VK_FIQ;
    if (brk_pend) kind = VK_BREAK;
    if (rst_pend) kind = VK_RESET;
  end

  assign vec = vec_addr(kind, int'(idx), N_LINE);
  assign req = kind != VK_IDLE;

endmodule

// File: rtl/prio_vec_evt.sv
module prio_vec_evt
  import prio_vec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rst_evt,
  input  logic      brk_evt,
  input  logic      ack,
  input  vec_kind_e kind,
  output logic      rst_pend,
  output logic      brk_pend
);

  logic take_rst;
  logic take_brk;

  assign take_rst = ack && kind == VK_RESET;
  assign take_brk = ack && kind == VK_BREAK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_pend <= 1'b0;
      brk_pend <= 1'b0;
    end else begin
      rst_pend <= rst_evt | (rst_pend & ~take_rst);
      brk_pend <= brk_evt | (brk_pend & ~take_brk);
    end
  end

endmodule

// File: rtl/prio_vec_ctrl.sv
module prio_vec_ctrl
  import prio_vec_pkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int N_LINE = NUM_LINE,
  parameter int DW     = DATA_W,
  localparam int LW    = $clog2(N_LINE),
  localparam int FW    = LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              brk_evt,
  input  logic              rst_evt,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [N_LINE-1:0] irq_line,
  output logic              fiq_line,
  output logic              irq_req,
  output logic [DW-1:0]     irq_vec,
  input  logic              irq_ack
);

  logic [N_SRC-1:0]  en_q;
  logic [N_SRC-1:0]  st_q;
  logic [FW-1:0]     fsel_q;
  logic [N_SRC-1:0]  edge_w;
  logic [N_LINE-1:0] line_w;
  logic              fiq_w;
  logic              rst_pend;
  logic              brk_pend;
  vec_kind_e         kind_w;

  prio_vec_srcreg #(.N_SRC(N_SRC), .N_LINE(N_LINE), .DW(DW), .FW(FW)) u_srcreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_req (src_req),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en_q    (en_q),
    .st_q    (st_q),
    .fsel_q  (fsel_q),
    .edge_o  (edge_w)
  );

  prio_vec_group #(.N_SRC(N_SRC), .N_LINE(N_LINE), .FW(FW), .LW(LW)) u_group (
    .st     (st_q),
    .en     (en_q),
    .fsel   (fsel_q),
    .line_o (line_w),
    .fiq_o  (fiq_w)
  );

  prio_vec_sel #(.N_LINE(N_LINE), .DW(DW), .LW(LW)) u_sel (
    .rst_pend (rst_pend),
    .brk_pend (brk_pend),
    .fiq      (fiq_w),
    .lines    (line_w),
    .kind     (kind_w),
    .vec      (irq_vec),
    .req      (irq_req)
  );

  prio_vec_evt u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_evt  (rst_evt),
    .brk_evt  (brk_evt),
    .ack      (irq_ack),
    .kind     (kind_w),
    .rst_pend (rst_pend),
    .brk_pend (brk_pend)
  );

  always_comb begin
    case (rd_addr)
      RA_ENABLE: rd_data = DW'(en_q);
      RA_STATUS: rd_data = DW'(st_q);
      RA_FIQSEL: rd_data = DW'(fsel_q);
      default:   rd_data = '0;
    endcase
  end

  assign irq_line = line_w;
  assign fiq_line = fiq_w;

endmodule

// File: rtl/prio_vec_chk.sv
module prio_vec_chk #(
  parameter int N_SRC  = 14,
  parameter int N_LINE = 8,
  parameter int DW     = 16,
  parameter int FW     = 4,
  parameter int LW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  edge_w,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic [N_SRC-1:0]  st_q,
  input logic [FW-1:0]     fsel_q,
  input logic [N_LINE-1:0] line_w,
  input logic              fiq_w,
  input logic              rst_pend,
  input logic              brk_pend,
  input logic              irq_ack,
  input logic              brk_evt,
  input logic              irq_req,
  input logic [DW-1:0]     irq_vec
);

  localparam logic [DW-1:0] V_BASE  = '1 - DW'(N_LINE) + DW'(1);
  localparam logic [DW-1:0] V_RESET = V_BASE - DW'(1);
  localparam logic [DW-1:0] V_BREAK = V_BASE - DW'(3);

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_w) |=> ((st_q & $past(edge_w)) == $past(edge_w))); // R2

  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> ((st_q & $past(wr_data[N_SRC-1:0] & ~edge_w)) == '0)); // R3

  AST_LINE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((|line_w) || fiq_w) |-> irq_req); // R5

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= V_BREAK)); // R6

  AST_FIQ_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fsel_q) < N_LINE) |-> !line_w[fsel_q[LW-1:0]]); // R7

  AST_RESET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |-> (irq_vec == V_RESET)); // R8

  AST_ACK_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_vec == V_BREAK && !brk_evt) |=> !brk_pend); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == '0)); // R10

endmodule

bind prio_vec_ctrl prio_vec_chk #(
  .N_SRC(N_SRC), .N_LINE(N_LINE), .DW(DW), .FW(FW), .LW(LW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .edge_w   (edge_w),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .st_q     (st_q),
  .fsel_q   (fsel_q),
  .line_w   (line_w),
  .fiq_w    (fiq_w),
  .rst_pend (rst_pend),
  .brk_pend (brk_pend),
  .irq_ack  (irq_ack),
  .brk_evt  (brk_evt),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec)
);

// File: tb/prio_vec_ctrl_bench.sv
module prio_vec_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] src_req = '0;
  logic        brk_evt = 1'b0;
  logic        rst_evt = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [7:0]  irq_line;
  logic        fiq_line;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic        irq_ack = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prio_vec_ctrl u_prio_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .brk_evt(brk_evt), .rst_evt(rst_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_line(irq_line), .fiq_line(fiq_line), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  typedef struct packed {
    logic [13:0] en;
    logic [13:0] st;
    logic [3:0]  fsel;
    logic [15:0] vec;
    logic [7:0]  lines;
    logic        fiq;
  } row_t;

  localparam int NROW = 12;
  localparam row_t TBL [NROW] = '{
    '{14'h3FFF, 14'h0001, 4'h8, 16'hFFFF, 8'h80, 1'b0},
    '{14'h3FFF, 14'h2000, 4'h8, 16'hFFFB, 8'h08, 1'b0},
    '{14'h3FFF, 14'h2001, 4'h8, 16'hFFFB, 8'h88, 1'b0},
    '{14'h0000, 14'h3FFF, 4'h8, 16'h0000, 8'h00, 1'b0},
    '{14'h1FFF, 14'h2000, 4'h8, 16'h0000, 8'h00, 1'b0},
    '{14'h3FFF, 14'h0009, 4'h8, 16'hFFF8, 8'h81, 1'b0},
    '{14'h3FFF, 14'h0009, 4'h7, 16'hFFF6, 8'h01, 1'b1},
    '{14'h3FFF, 14'h0040, 4'h2, 16'hFFFE, 8'h40, 1'b0},
    '{14'h3FFF, 14'h1000, 4'h2, 16'hFFF6, 8'h00, 1'b1},
    '{14'h3FFF, 14'h0180, 4'h8, 16'hFFFD, 8'h20, 1'b0},
    '{14'h0004, 14'h0004, 4'h8, 16'hFFF9, 8'h02, 1'b0},
    '{14'h3FFF, 14'h0E00, 4'h8, 16'hFFFA, 8'h0C, 1'b0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic pulse_brk();
    @(negedge clk); brk_evt = 1'b1;
    @(negedge clk); brk_evt = 1'b0;
    #1;
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst_evt = 1'b1;
    @(negedge clk); rst_evt = 1'b0;
    #1;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    check("R1 vec", irq_vec, 16'h0000);
    check("R1 req", {15'd0, irq_req}, 16'h0000);
    check("R1 lines", {8'd0, irq_line}, 16'h0000);
    rd_check("R1 enable", 2'd0, 16'h0000);
    rd_check("R1 status", 2'd1, 16'h0000);
    rd_check("R1 fiqsel", 2'd3, 16'h0008);

    // R4 register access
    wr(2'd0, 16'h1234);
    rd_check("R4 enable load", 2'd0, 16'h1234);
    wr(2'd3, 16'h0003);
    rd_check("R4 fiqsel load", 2'd3, 16'h0003);
    rd_check("R4 clear reads zero", 2'd2, 16'h0000);
    wr(2'd1, 16'h0005);
    wr(2'd1, 16'h0100);
    rd_check("R4 status set accumulates", 2'd1, 16'h0105);
    wr(2'd2, 16'h3FFF);
    rd_check("R3 clear all", 2'd1, 16'h0000);
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0008);

    // Table: R5 R6 R7 mapping and priority
    for (int i = 0; i < NROW; i++) begin
      wr(2'd2, 16'h3FFF);
      wr(2'd0, {2'b00, TBL[i].en});
      wr(2'd3, {12'd0, TBL[i].fsel});
      wr(2'd1, {2'b00, TBL[i].st});
      check($sformatf("table R5 R6 R7 row %0d vec", i), irq_vec, TBL[i].vec);
      check($sformatf("table R5 row %0d lines", i), {8'd0, irq_line}, {8'd0, TBL[i].lines});
      check($sformatf("table R7 row %0d fiq", i), {15'd0, fiq_line}, {15'd0, TBL[i].fiq});
      check($sformatf("table R10 row %0d req", i), {15'd0, irq_req},
            {15'd0, (TBL[i].vec != 16'h0000)});
    end

    wr(2'd2, 16'h3FFF);
    wr(2'd0, 16'h3FFF);
    wr(2'd3, 16'h0008);

    // R2 edge capture
    @(negedge clk); src_req[5] = 1'b1;
    @(negedge clk); #1;
    rd_check("R2 rise sets", 2'd1, 16'h0020);
    wr(2'd2, 16'h0020);
    repeat (2) @(negedge clk);
    #1;
    rd_check("R2 held level no reset", 2'd1, 16'h0000);
    @(negedge clk); src_req[5] = 1'b0;
    @(negedge clk); src_req[5] = 1'b1;
    @(negedge clk); #1;
    rd_check("R2 second rise sets", 2'd1, 16'h0020);
    wr(2'd2, 16'h0020);
    src_req[5] = 1'b0;

    // R3 rise and clear in the same cycle: set wins
    @(negedge clk);
    src_req[4] = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0010;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    rd_check("R3 set beats clear", 2'd1, 16'h0010);
    check("R6 line7 vector", irq_vec, 16'hFFFF);

    // R8 event priority
    pulse_brk();
    check("R8 break vector", irq_vec, 16'hFFF5);
    wr(2'd3, 16'h0007);
    check("R8 break over FIQ", irq_vec, 16'hFFF5);
    pulse_rst();
    check("R8 reset over break", irq_vec, 16'hFFF7);

    // R9 acknowledge
    pulse_ack();
    check("R9 ack retires reset", irq_vec, 16'hFFF5);
    pulse_ack();
    check("R9 ack retires break", irq_vec, 16'hFFF6);
    pulse_ack();
    check("R9 ack on FIQ no effect vec", irq_vec, 16'hFFF6);
    rd_check("R9 ack on FIQ keeps status", 2'd1, 16'h0010);

    pulse_brk();
    @(negedge clk); irq_ack = 1'b1; brk_evt = 1'b1;
    @(negedge clk); irq_ack = 1'b0; brk_evt = 1'b0;
    #1;
    check("R9 new break during ack kept", irq_vec, 16'hFFF5);
    pulse_ack();
    check("R9 break retired", irq_vec, 16'hFFF6);

    // R10 idle
    wr(2'd3, 16'h0008);
    check("R7 unrouted back to line", irq_vec, 16'hFFFF);
    wr(2'd2, 16'h3FFF);
    check("R10 idle vec", irq_vec, 16'h0000);
    check("R10 idle req", {15'd0, irq_req}, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule